// File: doc/BRIEF.md
# Serial Management Interface Master with Autonomous Polling

This block is the master side of a two-wire serial management link (a clock line and a bidirectional data line) that reads and writes 16-bit registers inside external transceivers. Software places a complete 32-bit command word in the frame register. The block sends a preamble and then the command, most significant bit first. When it is done it sets a completion flag, and after a read it places the returned data in the low half of the same register.

A watch mode can be enabled. In this mode the engine reads one chosen register of one chosen transceiver over and over. It keeps the most recent value, accumulates a flag for every bit that differs between two consecutive reads, and raises an interrupt when an accumulated flag is not masked.

A manual mode hands the clock, the data value and the output enable to three one-bit registers, so that software can drive the link by hand. There are two data pins. A select bit picks which pin carries the traffic and which input is sampled.

Top module: `mgmt_serial_master`

## Requirements
- R1: A frame written at offset 0 is sent as 32 ones followed by the 32 written bits, most significant bit first. The bit layout is: [31:30] start, [29:28] opcode, [27:23] transceiver address, [22:18] register address, [17:16] turnaround, [15:0] data. With opcode 01 (write), all 64 bits are driven.
- R2: While a frame is in progress, the clock output runs with a period of 2*DIV_HALF system cycles. The data output changes only while the clock is low, and the input is sampled at the rising clock edge.
- R3: With opcode 10 (read), the master stops driving from the first turnaround bit to the end of the frame. It samples the 16 bits that follow the turnaround, most significant bit first, into frame bits [15:0]. A line that nobody drives therefore reads 0xFFFF.
- R4: Frame bit 16 reads 0 from the cycle after a frame write until the transaction ends, and then reads 1.
- R5: A frame written while a watch read is in flight, or while manual mode is on, is held back. It runs once the engine is free and manual mode is off.
- R6: When configuration bit 1 is set and bit 2 is clear, the engine issues back-to-back reads of the transceiver in configuration bits [14:10] and the register in bits [7:3]. Status (offset 2) bits [31:16] hold the last value read.
- R7: Status bits [15:0] accumulate the XOR of each watched value with the previous one. The first read after watching is enabled sets no flags.
- R8: A read of the status register clears the change flags. A change detected in that same cycle is kept.
- R9: The interrupt output is high when a change flag is set and the matching mask bit (offset 3, bits [15:0]) is 0. The mask resets to 0xFFFF.
- R10: With configuration bit 2 set, the clock, the data output and the output enable follow the registers at offsets 4, 5 and 6 (bit 0 of each), and no frame starts.
- R11: Configuration bit 0 selects data pin 1 (1) or pin 0 (0). Only the selected pin's output enable can be high, and only the selected pin is sampled.
- R12: Configuration read-back bits 8 and 9 show the live levels of input pins 0 and 1.
- R13: After reset, the frame, status and configuration registers read 0, apart from the live pin bits. The mask reads 0xFFFF, and the clock, both output enables and the interrupt are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status flags at offset 2) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq | output | 1 | Unmasked change interrupt |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data value driven onto the selected pin |
| mdio0_oe | output | 1 | Output enable of data pin 0 |
| mdio1_oe | output | 1 | Output enable of data pin 1 |
| mdio0_i | input | 1 | Level sensed on data pin 0 |
| mdio1_i | input | 1 | Level sensed on data pin 1 |

## Verification
The bench sweeps every register address through a write and then a read-back against a transceiver model. If the turnaround were placed one bit off, the model and the master would drive the line at the same time, or the data would come back shifted. The preamble length, the clock period and the data stability while the clock is high are measured on the pins, so a miscounted preamble or data launched on the rising edge is caught. The watch-mode checks change a watched register behind the master's back. They would catch flags raised on the first read, flags lost when they coincide with a clear, and interrupts that ignore the mask. A frame queued during manual mode must wait and must not pulse the clock, and a swapped pin select shows up as activity on the wrong output enable.

// File: rtl/mif_pkg.sv
package mif_pkg;

  localparam int unsigned FRM_W    = 32;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned HDR_BITS = 14;  // start + opcode + two addresses

  typedef enum logic [2:0] {
    RA_FRAME  = 3'd0,
    RA_CFG    = 3'd1,
    RA_STAT   = 3'd2,
    RA_MASK   = 3'd3,
    RA_BBCLK  = 3'd4,
    RA_BBDATA = 3'd5,
    RA_BBOE   = 3'd6
  } mif_reg_e;

  // Command word for one autonomous watch read.
  function automatic logic [FRM_W-1:0] read_cmd(input logic [4:0] phy,
                                                 input logic [4:0] regad);
    return {2'b01, 2'b10, phy, regad, 2'b10, 16'h0000};
  endfunction

  function automatic logic is_read_op(input logic [FRM_W-1:0] f);
    return f[29:28] == 2'b10;
  endfunction

  // True when the master owns the line at bit slot idx of the transaction.
  function automatic logic drives_slot(input logic rd, input int unsigned idx,
                                       input int unsigned pre);
    return !rd || (idx < pre + HDR_BITS);
  endfunction

  function automatic logic [DATA_W-1:0] diff_bits(input logic [DATA_W-1:0] a,
                                                  input logic [DATA_W-1:0] b);
    return a ^ b;
  endfunction

endpackage

// File: rtl/mif_clkgen.sv
module mif_clkgen #(
  parameter int unsigned DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise,
  output logic fall
);
  localparam int unsigned CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] TOP = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap = run && (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc  = mdc_q;
  assign rise = wrap && !mdc_q;
  assign fall = wrap && mdc_q;

endmodule

// File: rtl/mif_shifter.sv
module mif_shifter
  import mif_pkg::*;
#(
  parameter int unsigned PRE_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FRM_W-1:0]  frame_in,
  input  logic              rise,
  input  logic              fall,
  input  logic              sdi,
  output logic              busy,
  output logic              sdo,
  output logic              soe,
  output logic              done,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned TXN      = PRE_BITS + FRM_W;
  localparam int unsigned IW       = $clog2(TXN);
  localparam int unsigned RD_FIRST = PRE_BITS + HDR_BITS + 2;
  localparam logic [IW-1:0] LAST_IDX = IW'(TXN - 1);

  logic [TXN-1:0]    sh_q;
  logic [IW-1:0]     idx_q;
  logic              is_rd_q;
  logic [DATA_W-1:0] rd_q;
  logic              busy_q;
  logic              done_q;
  logic              last_bit;
  logic              rd_slot;

  assign last_bit = (idx_q == LAST_IDX);
  assign rd_slot  = is_rd_q && (32'(idx_q) >= RD_FIRST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      sh_q    <= '0;
      idx_q   <= '0;
      is_rd_q <= 1'b0;
      rd_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q  <= 1'b1;
          sh_q    <= {{PRE_BITS{1'b1}}, frame_in};
          idx_q   <= '0;
          is_rd_q <= is_read_op(frame_in);
          rd_q    <= '0;
        end
      end else begin
        if (rise && rd_slot) rd_q <= {rd_q[DATA_W-2:0], sdi};
        if (fall) begin
          if (last_bit) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
            sh_q  <= {sh_q[TXN-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign busy    = busy_q;
  assign sdo     = sh_q[TXN-1];
  assign soe     = busy_q && drives_slot(is_rd_q, 32'(idx_q), PRE_BITS);
  assign done    = done_q;
  assign rd_data = rd_q;

  // R2: the bit on the line moves only on a falling-edge tick
  p_shift_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$past(fall)) |-> $stable(sh_q[TXN-1]));

  // R4: completion is a single-cycle event
  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R3: once released during a read, the line stays released to the end
  p_release_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && is_rd_q && !soe) |=> (!soe || !busy_q));

endmodule

// File: rtl/mif_poll.sv
module mif_poll
  import mif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res,
  input  logic              clr,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] basic,
  output logic [DATA_W-1:0] chg,
  output logic              irq
);
  logic              seen_q;
  logic [DATA_W-1:0] basic_q;
  logic [DATA_W-1:0] chg_q;
  logic [DATA_W-1:0] diff;

  assign diff = (res_valid && seen_q) ? diff_bits(basic_q, res) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      basic_q <= '0;
      chg_q   <= '0;
    end else begin
      if (!enable)        seen_q <= 1'b0;
      else if (res_valid) seen_q <= 1'b1;
      if (res_valid) basic_q <= res;
      chg_q <= (clr ? '0 : chg_q) | diff;
    end
  end

  assign basic = basic_q;
  assign chg   = chg_q;
  assign irq   = |(chg_q & ~mask);

  // R8: a clear with no new result leaves no flags
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !res_valid) |=> (chg_q == '0));

  // R7: the first result after enabling raises nothing
  p_first_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !seen_q && !clr) |=> (chg_q == $past(chg_q)));

endmodule

// File: rtl/mgmt_serial_master.sv
module mgmt_serial_master
  import mif_pkg::*;
#(
  parameter int unsigned DIV_HALF = 2,
  parameter int unsigned PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio0_oe,
  output logic        mdio1_oe,
  input  logic        mdio0_i,
  input  logic        mdio1_i
);
  mif_reg_e          addr_e;
  logic [FRM_W-1:0]  frame_q;
  logic              sw_pend_q, owner_q;
  logic              sel_q, poll_en_q, bb_en_q;
  logic [4:0]        poll_reg_q, poll_phy_q;
  logic [DATA_W-1:0] mask_q;
  logic              bb_clk_q, bb_dat_q, bb_oe_q;

  logic              frame_wr, stat_rd;
  logic              eng_busy, eng_done, eng_start;
  logic              eng_sdo, eng_soe, eng_sdi;
  logic              eng_mdc, eng_rise, eng_fall;
  logic [DATA_W-1:0] eng_rd;
  logic [FRM_W-1:0]  start_frame;
  logic              can_go, sw_go, poll_go;
  logic              oe_any;
  logic [DATA_W-1:0] poll_basic, poll_chg;
  logic              poll_irq;

  assign addr_e   = mif_reg_e'(reg_addr);
  assign frame_wr = reg_wr && (addr_e == RA_FRAME);
  assign stat_rd  = reg_rd && (addr_e == RA_STAT);

  // launch arbitration: software frame first, watch reads otherwise
  assign can_go      = !eng_busy && !eng_done && !bb_en_q;
  assign sw_go       = can_go && sw_pend_q;
  assign poll_go     = can_go && !sw_pend_q && poll_en_q && !frame_wr;
  assign eng_start   = sw_go || poll_go;
  assign start_frame = sw_go ? frame_q : read_cmd(poll_phy_q, poll_reg_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q    <= '0;
      sw_pend_q  <= 1'b0;
      owner_q    <= 1'b0;
      sel_q      <= 1'b0;
      poll_en_q  <= 1'b0;
      bb_en_q    <= 1'b0;
      poll_reg_q <= '0;
      poll_phy_q <= '0;
      mask_q     <= '1;
      bb_clk_q   <= 1'b0;
      bb_dat_q   <= 1'b0;
      bb_oe_q    <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (addr_e)
          RA_CFG: begin
            sel_q      <= reg_wdata[0];
            poll_en_q  <= reg_wdata[1];
            bb_en_q    <= reg_wdata[2];
            poll_reg_q <= reg_wdata[7:3];
            poll_phy_q <= reg_wdata[14:10];
          end
          RA_MASK:   mask_q   <= reg_wdata[15:0];
          RA_BBCLK:  bb_clk_q <= reg_wdata[0];
          RA_BBDATA: bb_dat_q <= reg_wdata[0];
          RA_BBOE:   bb_oe_q  <= reg_wdata[0];
          default: ;
        endcase
      end
      if (eng_start) owner_q <= sw_go;
      if (frame_wr) begin
        frame_q   <= reg_wdata & ~32'h0001_0000;
        sw_pend_q <= 1'b1;
      end else begin
        if (sw_go) sw_pend_q <= 1'b0;
        if (eng_done && owner_q && !sw_pend_q) begin
          frame_q[16] <= 1'b1;
          if (is_read_op(frame_q)) frame_q[15:0] <= eng_rd;
        end
      end
    end
  end

  mif_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(eng_busy),
    .mdc(eng_mdc), .rise(eng_rise), .fall(eng_fall)
  );

  mif_shifter #(.PRE_BITS(PRE_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .frame_in(start_frame),
    .rise(eng_rise), .fall(eng_fall), .sdi(eng_sdi),
    .busy(eng_busy), .sdo(eng_sdo), .soe(eng_soe), .done(eng_done),
    .rd_data(eng_rd)
  );

  mif_poll u_poll (
    .clk(clk), .rst_n(rst_n), .enable(poll_en_q && !bb_en_q),
    .res_valid(eng_done && !owner_q), .res(eng_rd), .clr(stat_rd),
    .mask(mask_q), .basic(poll_basic), .chg(poll_chg), .irq(poll_irq)
  );

  // pin muxing
  assign eng_sdi  = sel_q ? mdio1_i : mdio0_i;
  assign mdc      = bb_en_q ? bb_clk_q : eng_mdc;
  assign mdio_o   = bb_en_q ? bb_dat_q : eng_sdo;
  assign oe_any   = bb_en_q ? bb_oe_q  : eng_soe;
  assign mdio0_oe = oe_any && !sel_q;
  assign mdio1_oe = oe_any && sel_q;
  assign irq      = poll_irq;

  always_comb begin
    case (addr_e)
      RA_FRAME:  reg_rdata = frame_q;
      RA_CFG:    reg_rdata = {17'd0, poll_phy_q, mdio1_i, mdio0_i, poll_reg_q,
                              bb_en_q, poll_en_q, sel_q};
      RA_STAT:   reg_rdata = {poll_basic, poll_chg};
      RA_MASK:   reg_rdata = {16'd0, mask_q};
      RA_BBCLK:  reg_rdata = {31'd0, bb_clk_q};
      RA_BBDATA: reg_rdata = {31'd0, bb_dat_q};
      RA_BBOE:   reg_rdata = {31'd0, bb_oe_q};
      default:   reg_rdata = '0;
    endcase
  end

  // R11: never both pins driven
  p_pin_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mdio0_oe && mdio1_oe));

  // R10: manual mode starts nothing
  p_bb_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bb_en_q |-> !eng_start);

  // R4: completion flag drops on a new command and rises at the end
  p_cmp_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wr |=> !frame_q[16]);
  p_cmp_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && owner_q && !sw_pend_q && !frame_wr) |=> frame_q[16]);

endmodule

// File: tb/tb_mgmt_serial_master.sv
module tb_mgmt_serial_master;
  localparam int DIV = 2;
  localparam logic [4:0] PHY_AD = 5'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, mdc, mdio_o, mdio0_oe, mdio1_oe, line0, line1;
  logic p1_lvl = 1'b1;

  int total = 0, bad = 0, cyc = 0;

  // transceiver model state
  logic [15:0] phy_regs [32];
  int m_state = 0, m_ones = 0, m_n = 0, m_last_pre = 0;
  logic [13:0] m_hdr = '0;
  logic [15:0] m_data = '0, m_sh = '0;
  logic m_arm = 1'b0, m_oe = 1'b0, m_val = 1'b1;

  // pin monitors
  int conflict = 0, stab_viol = 0, oe0_cnt = 0, mdc_rises = 0;
  int last_rise = 0, mdc_period = 0;
  logic bb_phase = 1'b0, p_mdc = 1'b0, p_oe = 1'b0, p_o = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  assign line0 = mdio0_oe ? mdio_o : (m_oe ? m_val : 1'b1);
  assign line1 = mdio1_oe ? mdio_o : p1_lvl;

  mgmt_serial_master #(.DIV_HALF(DIV), .PRE_BITS(32)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .mdc(mdc), .mdio_o(mdio_o), .mdio0_oe(mdio0_oe),
    .mdio1_oe(mdio1_oe), .mdio0_i(line0), .mdio1_i(line1)
  );

  always @(posedge mdc) begin
    mdc_rises++;
    mdc_period = cyc - last_rise;
    last_rise = cyc;
    case (m_state)
      0: begin
        if (line0) m_ones++;
        else begin
          if (m_ones >= 32) begin
            m_last_pre = m_ones; m_state = 1; m_n = 1; m_hdr = '0;
          end
          m_ones = 0;
        end
      end
      1: begin
        m_hdr = {m_hdr[12:0], line0}; m_n++;
        if (m_n == 14) begin m_state = 2; m_n = 0; end
      end
      2: begin
        m_n++;
        if (m_n == 2) begin
          m_n = 0;
          if (m_hdr[9:5] != PHY_AD) m_state = 5;
          else if (m_hdr[11:10] == 2'b10) begin
            m_state = 4; m_sh = phy_regs[m_hdr[4:0]]; m_arm = 1'b1;
          end else begin m_state = 3; m_data = '0; end
        end
      end
      3: begin
        m_data = {m_data[14:0], line0}; m_n++;
        if (m_n == 16) begin
          phy_regs[m_hdr[4:0]] = m_data; m_state = 0; m_ones = 0;
        end
      end
      4: begin
        m_n++;
        if (m_n == 16) begin m_arm = 1'b0; m_oe = 1'b0; m_state = 0; m_ones = 0; end
      end
      default: begin
        m_n++;
        if (m_n == 16) begin m_state = 0; m_ones = 0; end
      end
    endcase
  end

  always @(negedge mdc) begin
    if (m_arm) begin
      m_oe = 1'b1; m_val = m_sh[15]; m_sh = {m_sh[14:0], 1'b0};
    end
  end

  always @(negedge clk) begin
    if (mdio0_oe && m_oe) conflict++;
    if (mdio0_oe) oe0_cnt++;
    if (!bb_phase && mdc && p_mdc && mdio0_oe && p_oe && (mdio_o != p_o)) stab_viol++;
    p_mdc = mdc; p_oe = mdio0_oe; p_o = mdio_o;
  end

  function automatic logic [15:0] wv(input int i);
    return 16'hC3A5 ^ 16'(i * 16'h1357);
  endfunction

  function automatic logic [31:0] frm(input logic [1:0] op, input logic [4:0] phy,
                                      input logic [4:0] ra, input logic [15:0] d);
    return {2'b01, op, phy, ra, 2'b10, d};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_done(output logic [31:0] f);
    for (int k = 0; k < 3000; k++) begin
      rd(3'd0, f);
      if (f[16]) return;
    end
    chk("R4 completion timeout", 32'd0, 32'd1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [15:0] v3;
    for (int i = 0; i < 32; i++) phy_regs[i] = 16'(i * 16'h0101) ^ 16'h00F0;
    idle(5);
    rst_n = 1'b1;
    idle(2);

    // R13 reset state
    rd(3'd0, r); chk("R13 frame", r, 32'h0);
    rd(3'd2, r); chk("R13 status", r, 32'h0);
    rd(3'd3, r); chk("R13 mask", r, 32'h0000FFFF);
    rd(3'd1, r); chk("R13 cfg", r, 32'h00000300);
    chk("R13 pins", {28'd0, irq, mdc, mdio0_oe, mdio1_oe}, 32'h0);

    // R12 live pin levels
    p1_lvl = 1'b0;
    rd(3'd1, r); chk("R12 cfg pins", {30'd0, r[9:8]}, 32'h1);
    p1_lvl = 1'b1;
    rd(3'd1, r); chk("R12 cfg pins", {30'd0, r[9:8]}, 32'h3);

    // R1 write sweep over all register addresses
    for (int i = 0; i < 32; i++) begin
      wr(3'd0, frm(2'b01, PHY_AD, 5'(i), wv(i)));
      if (i == 0) begin
        rd(3'd0, r); chk("R4 busy flag", {31'd0, r[16]}, 32'h0);
      end
      wait_done(r);
      chk("R1 model reg", {16'd0, phy_regs[i]}, {16'd0, wv(i)});
    end

    // R3 read sweep
    for (int i = 0; i < 32; i++) begin
      wr(3'd0, frm(2'b10, PHY_AD, 5'(i), 16'h0));
      wait_done(r);
      chk("R3 read data", {16'd0, r[15:0]}, {16'd0, wv(i)});
      if (i == 0) begin
        chk("R1 preamble length", m_last_pre, 32);
        chk("R2 mdc period", mdc_period, 2 * DIV);
      end
    end
    chk("R3 no line conflict", conflict, 0);
    chk("R2 data stable while mdc high", stab_viol, 0);

    // R3 absent transceiver reads all ones
    wr(3'd0, frm(2'b10, 5'd7, 5'd3, 16'h0));
    wait_done(r);
    chk("R3 undriven line", {16'd0, r[15:0]}, 32'h0000FFFF);

    // R11 pin select
    wr(3'd1, 32'h1);
    oe0_cnt = 0;
    wr(3'd0, frm(2'b10, PHY_AD, 5'd2, 16'h0));
    wait_done(r);
    chk("R11 sampled pin 1", {16'd0, r[15:0]}, 32'h0000FFFF);
    chk("R11 pin0 oe quiet", oe0_cnt, 0);
    wr(3'd1, 32'h0);

    // R6..R9 watch mode on register 3
    v3 = phy_regs[3];
    wr(3'd1, (32'(PHY_AD) << 10) | (32'd3 << 3) | 32'h2);
    idle(700);
    rd(3'd2, r); chk("R6 last value", r, {v3, 16'h0});
    chk("R7 first read quiet", {31'd0, irq}, 32'h0);
    phy_regs[3] = v3 ^ 16'h0104;
    idle(800);
    chk("R9 masked irq", {31'd0, irq}, 32'h0);
    wr(3'd3, 32'h0000FFFB);
    chk("R9 unmasked irq", {31'd0, irq}, 32'h1);
    rd(3'd2, r); chk("R7 change flags", r, {v3 ^ 16'h0104, 16'h0104});
    rd(3'd2, r); chk("R8 flags cleared", {16'd0, r[15:0]}, 32'h0);
    chk("R8 irq cleared", {31'd0, irq}, 32'h0);

    // R5 software frame during watch
    wr(3'd0, frm(2'b01, PHY_AD, 5'd9, 16'hBEEF));
    wait_done(r);
    chk("R5 frame during watch", {16'd0, phy_regs[9]}, 32'h0000BEEF);

    phy_regs[3] = v3 ^ 16'h0114;
    idle(800);
    chk("R9 bit4 masked irq", {31'd0, irq}, 32'h0);
    rd(3'd2, r); chk("R7 masked flag", r, {v3 ^ 16'h0114, 16'h0010});
    wr(3'd1, 32'h0);
    idle(400);

    // R10 manual mode
    bb_phase = 1'b1;
    wr(3'd5, 32'h0); wr(3'd6, 32'h1); wr(3'd1, 32'h4); wr(3'd4, 32'h1);
    chk("R10 manual pins", {28'd0, mdc, mdio_o, mdio0_oe, mdio1_oe}, 32'hA);
    wr(3'd1, 32'h5);
    chk("R11 manual select", {28'd0, mdc, mdio_o, mdio0_oe, mdio1_oe}, 32'h9);
    wr(3'd4, 32'h0); wr(3'd6, 32'h0); wr(3'd1, 32'h4);
    mdc_rises = 0;
    wr(3'd0, frm(2'b01, PHY_AD, 5'd12, 16'h5A5A));
    idle(300);
    rd(3'd0, r); chk("R10 frame held", {31'd0, r[16]}, 32'h0);
    chk("R10 mdc quiet", mdc_rises, 0);
    wr(3'd1, 32'h0);
    bb_phase = 1'b0;
    wait_done(r);
    chk("R5 held frame runs", {16'd0, phy_regs[12]}, 32'h00005A5A);
    chk("R3 no line conflict end", conflict, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule